// File: doc/BRIEF.md
# Grouping Instruction Queue

This block sits between instruction decode and the execution units of a superscalar core. Fetch writes up to four pre-decoded instructions per cycle into a twelve-entry circular queue. Every cycle the block looks at the four oldest entries and forms an issue group. The group grows one slot at a time from the head. It stops at the first instruction that cannot go, because of a unit limit, a slot restriction, a dependency on a result produced earlier in the same group, or a source register that a pending-write scoreboard still marks as busy. The entries in the group leave the queue at the next clock edge. Because the group is always taken from the head, how fetch happened to align the instructions makes no difference.

Each entry carries a unit class and three register specifiers, each with a use bit. The group former gives each issued slot a unit code and reports how many entries were consumed. A store that gets its data from an integer instruction in the same group may still issue with it; it is marked as taking that data by forwarding. A flush input empties the queue in one cycle, for use on mispredicted branches.

A small fill-state machine tracks occupancy and drives the ready signal back to fetch. It has three states. ST_EMPTY means no entries, ST_OPEN means one to eight entries, and ST_TIGHT means more than eight. The transitions are T_FILL (ST_EMPTY to ST_OPEN or ST_TIGHT), T_CLOSE (ST_OPEN to ST_TIGHT), T_REOPEN (ST_TIGHT to ST_OPEN) and T_DRAIN (any state to ST_EMPTY, which is also taken on a flush).

Top module: `iq_group_dispatch`

## Requirements
- R1: After reset the queue is empty, `in_ready` is 1, `iss_valid` is 0 and `iss_pop` is 0.
- R2: The queue holds 12 entries. `in_ready` is 1 exactly when at most 8 entries are occupied. A write offered while `in_ready` is 0 is discarded. The write itself works like this: `in_num` (0 to 4; larger values act as 4) entries are taken from `in_insts`, with slot 0 (bits 20:0) the oldest. Each 21-bit entry is packed as class[20:18], dst[17:13], dst_we[12], src1[11:7], src1_use[6], src2[5:1], src2_use[0].
- R3: Issue is in order. Issue slot k carries the k-th oldest entry. `iss_valid` is contiguous from slot 0, and the group ends at the first entry that is blocked. `iss_pop` equals the number of valid slots, and exactly those entries leave the queue.
- R4: Slot 3 issues only class 3 (branch) or class 4 (floating-point/graphics).
- R5: Unit limits per group are two integer (class 0 and reserved codes 5 to 7), one load/store (class 1 load, class 2 store), one branch and NFP=2 floating-point. The unit codes are 0 and 1 for the two integer ALUs, 2 for load/store, 3 for branch, and 4 plus an index for the floating-point units.
- R6: An instruction whose used source matches the written destination of an earlier slot in the same group does not issue, so two dependent integer operations never issue together.
- R7: A store (class 2) whose data source (src2) is written by an earlier integer instruction in the same group issues with it and raises `iss_fwd` for its slot. A dependency on its address source (src1), or a data producer that is not integer, blocks it.
- R8: An instruction with a used source whose `sb_pending` bit is 1 does not issue. A source whose use bit is 0 is ignored.
- R9: A flush empties the queue at the next edge. No slot issues in the flush cycle, and a write offered in that cycle is discarded.
- R10: A write and an issue in the same cycle both take effect, and the original order of all entries is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the queue |
| in_num | input | 3 | Number of entries written this cycle |
| in_insts | input | 84 | Four packed 21-bit entries, slot 0 oldest |
| in_ready | output | 1 | At least four entries free |
| sb_pending | input | 32 | Pending-write bit per architectural register |
| iss_valid | output | 4 | Per-slot issue valid |
| iss_unit | output | 12 | Per-slot 3-bit unit code |
| iss_fwd | output | 4 | Per-slot store-data forwarding flag |
| iss_inst | output | 84 | Per-slot entry contents |
| iss_pop | output | 3 | Entries consumed this cycle |

## Verification
The bound checker watches every cycle for properties that hold on any group. The valid mask must be contiguous and match the pop count. Slot 3 must carry only branch or floating-point work, and no unit class may exceed its limit. No issued source may be pending in the scoreboard. No issued instruction may read a result written earlier in its own group, except for forwarded store data, which must raise the forwarding flag. Behaviour that depends on history can only be shown by the bench's scenarios: that the group stops at the right slot for a given mix, that the ready signal falls at nine entries, that writes are dropped while it is low, that order survives wrap-around and simultaneous writes and issues, and that a flush discards both the stored and the offered entries.

// File: rtl/iq_pkg.sv
package iq_pkg;
    localparam int SLOTS = 4;
    localparam int REGW  = 5;
    localparam int NREG  = 1 << REGW;
    localparam int UNITW = 3;
    localparam int PCW   = $clog2(SLOTS + 1);

    typedef enum logic [2:0] {
        CLS_INT    = 3'd0,
        CLS_LOAD   = 3'd1,
        CLS_STORE  = 3'd2,
        CLS_BRANCH = 3'd3,
        CLS_FPG    = 3'd4
    } iclass_e;

    typedef enum logic [UNITW-1:0] {
        U_INT0 = 3'd0,
        U_INT1 = 3'd1,
        U_LSU  = 3'd2,
        U_BRU  = 3'd3,
        U_FP0  = 3'd4
    } unit_e;

    typedef struct packed {
        logic [2:0]      cls;
        logic [REGW-1:0] dst;
        logic            dst_we;
        logic [REGW-1:0] src1;
        logic            src1_use;
        logic [REGW-1:0] src2;
        logic            src2_use;
    } iq_entry_t;

    localparam int ENTW = $bits(iq_entry_t);

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_OPEN  = 2'd1,
        ST_TIGHT = 2'd2
    } fill_state_e;

    function automatic logic is_int_class(input logic [2:0] c);
        return !(c == CLS_LOAD || c == CLS_STORE || c == CLS_BRANCH || c == CLS_FPG);
    endfunction
endpackage

// File: rtl/iq_storage.sv
module iq_storage
    import iq_pkg::*;
#(
    parameter int DEPTH = 12,
    localparam int PTRW = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic                        wr_en,
    input  logic [PCW-1:0]              wr_num,
    input  iq_entry_t [SLOTS-1:0]       wr_data,
    input  logic [PCW-1:0]              pop,
    output iq_entry_t [SLOTS-1:0]       head_ent,
    output logic [SLOTS-1:0]            head_vld,
    output logic [CNTW-1:0]             count_next
);
    iq_entry_t       mem [DEPTH];
    logic [PTRW-1:0] head;
    logic [PTRW-1:0] tail;
    logic [CNTW-1:0] count;
    logic [PCW-1:0]  wr_eff;

    function automatic logic [PTRW-1:0] wrap_add(input logic [PTRW-1:0] p, input int unsigned d);
        int unsigned s;
        s = int'(p) + d;
        if (s >= DEPTH) s = s - DEPTH;
        return PTRW'(s);
    endfunction

    assign wr_eff = wr_en ? wr_num : '0;

    always_comb begin
        if (flush) count_next = '0;
        else       count_next = count + CNTW'(wr_eff) - CNTW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else if (flush) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            head  <= wrap_add(head, int'(pop));
            tail  <= wrap_add(tail, int'(wr_eff));
            count <= count_next;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < SLOTS; i++) begin
            if (!flush && i < int'(wr_eff)) mem[wrap_add(tail, i)] <= wr_data[i];
        end
    end

    generate
        for (genvar k = 0; k < SLOTS; k++) begin : g_head
            assign head_ent[k] = mem[wrap_add(head, k)];
            assign head_vld[k] = (int'(count) > k);
        end
    endgenerate
endmodule

// File: rtl/iq_fill_fsm.sv
module iq_fill_fsm
    import iq_pkg::*;
#(
    parameter int DEPTH = 12,
    localparam int CNTW = $clog2(DEPTH + 1),
    localparam int ROOM_LIM = DEPTH - SLOTS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CNTW-1:0] count_next,
    output logic            in_ready,
    output logic            q_nonempty
);
    fill_state_e state;
    fill_state_e state_nx;
    logic        nx_zero;
    logic        nx_tight;

    assign nx_zero  = (count_next == '0);
    assign nx_tight = (int'(count_next) > ROOM_LIM);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: begin
                if (!nx_zero) state_nx = nx_tight ? ST_TIGHT : ST_OPEN;   // T_FILL
            end
            ST_OPEN: begin
                if (nx_zero)       state_nx = ST_EMPTY;                   // T_DRAIN
                else if (nx_tight) state_nx = ST_TIGHT;                   // T_CLOSE
            end
            ST_TIGHT: begin
                if (nx_zero)       state_nx = ST_EMPTY;                   // T_DRAIN
                else if (!nx_tight) state_nx = ST_OPEN;                   // T_REOPEN
            end
            default: state_nx = ST_EMPTY;
        endcase
    end

    always_comb begin
        in_ready   = 1'b1;
        q_nonempty = 1'b1;
        unique case (state)
            ST_EMPTY: q_nonempty = 1'b0;
            ST_OPEN:  ;
            ST_TIGHT: in_ready = 1'b0;
            default: begin
                in_ready   = 1'b0;
                q_nonempty = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/iq_group_former.sv
module iq_group_former
    import iq_pkg::*;
#(
    parameter int NFP  = 2,
    parameter int NINT = 2
) (
    input  logic                        issue_en,
    input  iq_entry_t [SLOTS-1:0]       head_ent,
    input  logic [SLOTS-1:0]            head_vld,
    input  logic [NREG-1:0]             sb_pending,
    output logic [SLOTS-1:0]            slot_vld,
    output logic [SLOTS-1:0][UNITW-1:0] slot_unit,
    output logic [SLOTS-1:0]            slot_fwd,
    output logic [PCW-1:0]              pop
);
    always_comb begin
        logic        stop;
        logic        ok;
        logic        fwd;
        logic [UNITW-1:0] unit;
        int unsigned n_int, n_ls, n_br, n_fp;
        iq_entry_t   e;
        iq_entry_t   p;

        stop  = 1'b0;
        n_int = 0;
        n_ls  = 0;
        n_br  = 0;
        n_fp  = 0;
        pop   = '0;
        slot_vld  = '0;
        slot_unit = '0;
        slot_fwd  = '0;

        for (int k = 0; k < SLOTS; k++) begin
            e    = head_ent[k];
            ok   = issue_en && head_vld[k] && !stop;
            fwd  = 1'b0;
            unit = U_INT0;

            if (e.cls == CLS_LOAD || e.cls == CLS_STORE) begin
                if (n_ls >= 1) ok = 1'b0;
                unit = U_LSU;
            end else if (e.cls == CLS_BRANCH) begin
                if (n_br >= 1) ok = 1'b0;
                unit = U_BRU;
            end else if (e.cls == CLS_FPG) begin
                if (n_fp >= NFP) ok = 1'b0;
                unit = UNITW'(int'(U_FP0) + int'(n_fp));
            end else begin
                if (n_int >= NINT) ok = 1'b0;
                unit = UNITW'(int'(U_INT0) + int'(n_int));
            end

            if (k == SLOTS - 1 && !(e.cls == CLS_BRANCH || e.cls == CLS_FPG)) ok = 1'b0;

            if (e.src1_use && sb_pending[e.src1]) ok = 1'b0;
            if (e.src2_use && sb_pending[e.src2]) ok = 1'b0;

            for (int j = 0; j < k; j++) begin
                p = head_ent[j];
                if (p.dst_we) begin
                    if (e.src1_use && e.src1 == p.dst) ok = 1'b0;
                    if (e.src2_use && e.src2 == p.dst) begin
                        if (e.cls == CLS_STORE && is_int_class(p.cls)) fwd = 1'b1;
                        else                                           ok  = 1'b0;
                    end
                end
            end

            if (ok) begin
                slot_vld[k]  = 1'b1;
                slot_unit[k] = unit;
                slot_fwd[k]  = fwd;
                pop          = pop + 1'b1;
                if (e.cls == CLS_LOAD || e.cls == CLS_STORE) n_ls++;
                else if (e.cls == CLS_BRANCH)                n_br++;
                else if (e.cls == CLS_FPG)                   n_fp++;
                else                                         n_int++;
            end else begin
                stop = 1'b1;
            end
        end
    end
endmodule

// File: rtl/iq_group_dispatch.sv
module iq_group_dispatch
    import iq_pkg::*;
#(
    parameter int DEPTH = 12,
    parameter int NFP   = 2,
    parameter int NINT  = 2,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic [2:0]               in_num,
    input  logic [SLOTS*ENTW-1:0]    in_insts,
    output logic                     in_ready,
    input  logic [NREG-1:0]          sb_pending,
    output logic [SLOTS-1:0]         iss_valid,
    output logic [SLOTS*UNITW-1:0]   iss_unit,
    output logic [SLOTS-1:0]         iss_fwd,
    output logic [SLOTS*ENTW-1:0]    iss_inst,
    output logic [PCW-1:0]           iss_pop
);
    iq_entry_t [SLOTS-1:0]        wr_data;
    iq_entry_t [SLOTS-1:0]        head_ent;
    logic [SLOTS-1:0]             head_vld;
    logic [CNTW-1:0]              count_next;
    logic [PCW-1:0]               wr_num;
    logic                         wr_en;
    logic                         q_nonempty;
    logic                         issue_en;
    logic [SLOTS-1:0][UNITW-1:0]  slot_unit;

    assign wr_num   = (int'(in_num) > SLOTS) ? PCW'(SLOTS) : PCW'(in_num);
    assign wr_en    = in_ready && !flush && (wr_num != '0);
    assign issue_en = q_nonempty && !flush;

    generate
        for (genvar i = 0; i < SLOTS; i++) begin : g_flat
            assign wr_data[i]                     = in_insts[i*ENTW +: ENTW];
            assign iss_inst[i*ENTW +: ENTW]       = head_ent[i];
            assign iss_unit[i*UNITW +: UNITW]     = slot_unit[i];
        end
    endgenerate

    iq_storage #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .wr_en      (wr_en),
        .wr_num     (wr_num),
        .wr_data    (wr_data),
        .pop        (iss_pop),
        .head_ent   (head_ent),
        .head_vld   (head_vld),
        .count_next (count_next)
    );

    iq_fill_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_next (count_next),
        .in_ready   (in_ready),
        .q_nonempty (q_nonempty)
    );

    iq_group_former #(.NFP(NFP), .NINT(NINT)) u_group (
        .issue_en   (issue_en),
        .head_ent   (head_ent),
        .head_vld   (head_vld),
        .sb_pending (sb_pending),
        .slot_vld   (iss_valid),
        .slot_unit  (slot_unit),
        .slot_fwd   (iss_fwd),
        .pop        (iss_pop)
    );
endmodule

// File: rtl/iq_group_dispatch_chk.sv
module iq_group_dispatch_chk
    import iq_pkg::*;
#(
    parameter int NFP  = 2,
    parameter int NINT = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   flush,
    input logic [NREG-1:0]        sb_pending,
    input logic [SLOTS-1:0]       iss_valid,
    input logic [SLOTS*UNITW-1:0] iss_unit,
    input logic [SLOTS-1:0]       iss_fwd,
    input logic [SLOTS*ENTW-1:0]  iss_inst,
    input logic [PCW-1:0]         iss_pop
);
    iq_entry_t        ent [SLOTS];
    logic [SLOTS-1:0] int_v, ls_v, br_v, fp_v;

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_dec
            assign ent[g]   = iq_entry_t'(iss_inst[g*ENTW +: ENTW]);
            assign int_v[g] = iss_valid[g] && is_int_class(ent[g].cls);
            assign ls_v[g]  = iss_valid[g] && (ent[g].cls == CLS_LOAD || ent[g].cls == CLS_STORE);
            assign br_v[g]  = iss_valid[g] && (ent[g].cls == CLS_BRANCH);
            assign fp_v[g]  = iss_valid[g] && (ent[g].cls == CLS_FPG);

            // R8: issued sources are never pending
            assert_sb_src1_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (iss_valid[g] && ent[g].src1_use) |-> !sb_pending[ent[g].src1]);
            assert_sb_src2_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (iss_valid[g] && ent[g].src2_use) |-> !sb_pending[ent[g].src2]);
            // R7: forwarding flag only on an issued store
            assert_fwd_is_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
                iss_fwd[g] |-> (iss_valid[g] && ent[g].cls == CLS_STORE));
            // R5: load/store slots go to the load/store unit
            assert_ls_unit_R5: assert property (@(posedge clk) disable iff (!rst_n)
                ls_v[g] |-> (iss_unit[g*UNITW +: UNITW] == U_LSU));

            for (genvar j = 0; j < g; j++) begin : g_pair
                // R6: no same-group read of an earlier result on the first source
                assert_no_raw_src1_R6: assert property (@(posedge clk) disable iff (!rst_n)
                    (iss_valid[g] && ent[j].dst_we && ent[g].src1_use) |-> (ent[g].src1 != ent[j].dst));
                // R6/R7: a second-source match is only allowed as forwarded store data
                assert_raw_src2_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
                    (iss_valid[g] && ent[j].dst_we && ent[g].src2_use && ent[g].src2 == ent[j].dst)
                    |-> (ent[g].cls == CLS_STORE && is_int_class(ent[j].cls) && iss_fwd[g]));
            end
        end
    endgenerate

    // R3: valid slots are contiguous from slot 0 and the pop count matches
    assert_contiguous_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((iss_valid >> 1) & ~iss_valid) == '0);
    assert_pop_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(iss_pop) == $countones(iss_valid));
    // R4: last slot restricted to branch or floating-point work
    assert_last_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[SLOTS-1] |-> (ent[SLOTS-1].cls == CLS_BRANCH || ent[SLOTS-1].cls == CLS_FPG));
    // R5: per-class unit limits
    assert_int_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(int_v) <= NINT);
    assert_ls_single_R5: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ls_v));
    assert_br_single_R5: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(br_v));
    assert_fp_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fp_v) <= NFP);
    // R9: nothing issues during a flush nor in the cycle after it
    assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (iss_valid == '0));
    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush) |-> (iss_valid == '0));
endmodule

bind iq_group_dispatch iq_group_dispatch_chk #(.NFP(NFP), .NINT(NINT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .sb_pending (sb_pending),
    .iss_valid  (iss_valid),
    .iss_unit   (iss_unit),
    .iss_fwd    (iss_fwd),
    .iss_inst   (iss_inst),
    .iss_pop    (iss_pop)
);

// File: tb/iq_group_dispatch_test.sv
`timescale 1ns/1ps
module iq_group_dispatch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [2:0]  in_num = '0;
    logic [83:0] in_insts = '0;
    logic        in_ready;
    logic [31:0] sb_pending = '0;
    logic [3:0]  iss_valid;
    logic [11:0] iss_unit;
    logic [3:0]  iss_fwd;
    logic [83:0] iss_inst;
    logic [2:0]  iss_pop;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int rec [64];
    int rec_n = 0;
    logic s_ready;

    always #2.5 clk = ~clk;

    iq_group_dispatch uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_num(in_num), .in_insts(in_insts),
        .in_ready(in_ready), .sb_pending(sb_pending), .iss_valid(iss_valid),
        .iss_unit(iss_unit), .iss_fwd(iss_fwd), .iss_inst(iss_inst), .iss_pop(iss_pop)
    );

    function automatic logic [20:0] e_int(int d, int a, int b);
        return {3'd0, 5'(d), 1'b1, 5'(a), 1'b1, 5'(b), 1'b1};
    endfunction
    function automatic logic [20:0] e_int1(int d, int a);
        return {3'd0, 5'(d), 1'b1, 5'(a), 1'b1, 5'd9, 1'b0};
    endfunction
    function automatic logic [20:0] e_ld(int d, int a);
        return {3'd1, 5'(d), 1'b1, 5'(a), 1'b1, 5'd0, 1'b0};
    endfunction
    function automatic logic [20:0] e_st(int a, int dat);
        return {3'd2, 5'd0, 1'b0, 5'(a), 1'b1, 5'(dat), 1'b1};
    endfunction
    function automatic logic [20:0] e_br(int a);
        return {3'd3, 5'd0, 1'b0, 5'(a), 1'b1, 5'd0, 1'b0};
    endfunction
    function automatic logic [20:0] e_fp(int d, int a, int b);
        return {3'd4, 5'(d), 1'b1, 5'(a), 1'b1, 5'(b), 1'b1};
    endfunction

    typedef struct packed {
        logic [2:0]  n;
        logic [83:0] ins;
        logic [31:0] sb;
        logic [3:0]  ev;
        logic [3:0]  ef;
        logic [11:0] eu;
        logic [2:0]  ep;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        // R3 R5: full mixed group
        '{3'd4, {e_br(9), e_ld(7,8), e_int(4,5,6), e_int(1,2,3)}, 32'h0, 4'b1111, 4'b0, {3'd3,3'd2,3'd1,3'd0}, 3'd4, 4'd5},
        // R5 R3: third integer stops the group before the branch
        '{3'd4, {e_br(9), e_int(7,8,8), e_int(4,5,6), e_int(1,2,3)}, 32'h0, 4'b0011, 4'b0, {3'd0,3'd0,3'd1,3'd0}, 3'd2, 4'd5},
        // R4: integer in slot 3 held back
        '{3'd4, {e_int(1,2,3), e_fp(10,11,12), e_br(9), e_ld(7,8)}, 32'h0, 4'b0111, 4'b0, {3'd0,3'd4,3'd3,3'd2}, 3'd3, 4'd4},
        // R6: dependent integer pair
        '{3'd4, {e_br(9), e_ld(7,8), e_int(2,1,3), e_int(1,4,5)}, 32'h0, 4'b0001, 4'b0, 12'd0, 3'd1, 4'd6},
        // R7: store data forwarded from integer producer
        '{3'd4, {e_fp(10,11,12), e_br(9), e_st(3,5), e_int(5,1,2)}, 32'h0, 4'b1111, 4'b0010, {3'd4,3'd3,3'd2,3'd0}, 3'd4, 4'd7},
        // R7: store address dependency blocks
        '{3'd4, {e_br(9), e_br(9), e_st(5,6), e_int(5,1,2)}, 32'h0, 4'b0001, 4'b0, 12'd0, 3'd1, 4'd7},
        // R8: head blocked by scoreboard
        '{3'd1, {63'd0, e_int(1,2,3)}, 32'h4, 4'b0000, 4'b0, 12'd0, 3'd0, 4'd8},
        // R8: second slot blocked by scoreboard
        '{3'd2, {42'd0, e_int(6,2,3), e_int(1,4,5)}, 32'h4, 4'b0001, 4'b0, 12'd0, 3'd1, 4'd8},
        // R5: third floating-point op exceeds limit
        '{3'd4, {e_br(9), e_fp(13,14,15), e_fp(10,11,12), e_fp(16,17,18)}, 32'h0, 4'b0011, 4'b0, {3'd0,3'd0,3'd5,3'd4}, 3'd2, 4'd5},
        // R5: one load/store per group
        '{3'd2, {42'd0, e_st(3,4), e_ld(7,8)}, 32'h0, 4'b0001, 4'b0, {3'd0,3'd0,3'd0,3'd2}, 3'd1, 4'd5},
        // R8: unused source ignores scoreboard
        '{3'd1, {63'd0, e_int1(1,2)}, 32'h200, 4'b0001, 4'b0, 12'd0, 3'd1, 4'd8},
        // R7: floating-point producer does not forward store data
        '{3'd2, {42'd0, e_st(3,5), e_fp(5,1,2)}, 32'h0, 4'b0001, 4'b0, {3'd0,3'd0,3'd0,3'd4}, 3'd1, 4'd7},
        // R6: second-source dependency between integers
        '{3'd2, {42'd0, e_int(6,3,5), e_int(5,1,2)}, 32'h0, 4'b0001, 4'b0, 12'd0, 3'd1, 4'd6}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] n, input logic [83:0] ins, input logic [31:0] sb, input logic fl);
        @(negedge clk);
        in_num = n;
        in_insts = ins;
        sb_pending = sb;
        flush = fl;
        #1;
        s_ready = in_ready;
        for (int k = 0; k < 4; k++) begin
            if (iss_valid[k] && rec_n < 64) begin
                rec[rec_n] = int'(iss_inst[k*21+17 -: 5]);
                rec_n++;
            end
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [11:0] mask;
        logic [83:0] blk0, blk1, blk2, xs;
        int pops;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        chk(iss_valid == 4'b0, "R1 iss_valid", int'(iss_valid), 0);
        chk(iss_pop == 3'd0, "R1 iss_pop", int'(iss_pop), 0);

        for (int v = 0; v < NV; v++) begin
            step(3'd0, '0, '0, 1'b1);
            step(VEC[v].n, VEC[v].ins, '0, 1'b0);
            step(3'd0, '0, VEC[v].sb, 1'b0);
            mask = {{3{VEC[v].ev[3]}}, {3{VEC[v].ev[2]}}, {3{VEC[v].ev[1]}}, {3{VEC[v].ev[0]}}};
            chk(iss_valid == VEC[v].ev, $sformatf("R%0d vec%0d valid", VEC[v].req, v), int'(iss_valid), int'(VEC[v].ev));
            chk(iss_pop == VEC[v].ep, $sformatf("R%0d vec%0d pop", VEC[v].req, v), int'(iss_pop), int'(VEC[v].ep));
            chk(iss_fwd == VEC[v].ef, $sformatf("R%0d vec%0d fwd", VEC[v].req, v), int'(iss_fwd), int'(VEC[v].ef));
            chk((iss_unit & mask) == VEC[v].eu, $sformatf("R%0d vec%0d unit", VEC[v].req, v), int'(iss_unit & mask), int'(VEC[v].eu));
        end

        // R2: capacity, ready threshold and dropped writes
        blk0 = {e_int(6,2,2), e_int(5,2,2), e_int(4,2,2), e_int(3,2,2)};
        blk1 = {e_int(10,2,2), e_int(9,2,2), e_int(8,2,2), e_int(7,2,2)};
        blk2 = {e_int(14,2,2), e_int(13,2,2), e_int(12,2,2), e_int(11,2,2)};
        xs   = {e_int(23,2,2), e_int(22,2,2), e_int(21,2,2), e_int(20,2,2)};
        step(3'd0, '0, '0, 1'b1);
        rec_n = 0;
        step(3'd4, blk0, 32'h4, 1'b0);
        step(3'd4, blk1, 32'h4, 1'b0);
        chk(s_ready == 1'b1, "R2 ready at 4", int'(s_ready), 1);
        step(3'd4, blk2, 32'h4, 1'b0);
        chk(s_ready == 1'b1, "R2 ready at 8", int'(s_ready), 1);
        step(3'd4, xs, 32'h4, 1'b0);
        chk(s_ready == 1'b0, "R2 ready low at 12", int'(s_ready), 0);
        chk(rec_n == 0, "R8 blocked while pending", rec_n, 0);
        for (int c = 0; c < 10; c++) step(3'd0, '0, '0, 1'b0);
        chk(rec_n == 12, "R2 twelve entries drained", rec_n, 12);
        for (int i = 0; i < 12; i++)
            chk(rec[i] == 3 + i, "R3 drain order", rec[i], 3 + i);
        chk(s_ready == 1'b1, "R2 ready after drain", int'(s_ready), 1);

        // R10: writes while issuing keep order
        step(3'd0, '0, '0, 1'b1);
        rec_n = 0;
        step(3'd4, blk0, '0, 1'b0);
        step(3'd4, blk1, '0, 1'b0);
        pops = rec_n;
        chk(pops == 2, "R10 issue during write", pops, 2);
        for (int c = 0; c < 6; c++) step(3'd0, '0, '0, 1'b0);
        chk(rec_n == 8, "R10 total issued", rec_n, 8);
        for (int i = 0; i < 8; i++)
            chk(rec[i] == 3 + i, "R10 order", rec[i], 3 + i);

        // R9: flush drops stored and offered entries
        step(3'd0, '0, '0, 1'b1);
        step(3'd4, blk0, 32'h4, 1'b0);
        step(3'd4, blk1, '0, 1'b1);
        chk(iss_valid == 4'b0, "R9 no issue in flush cycle", int'(iss_valid), 0);
        rec_n = 0;
        step(3'd0, '0, '0, 1'b0);
        chk(iss_valid == 4'b0, "R9 empty after flush", int'(iss_valid), 0);
        step(3'd0, '0, '0, 1'b0);
        chk(rec_n == 0, "R9 offered write discarded", rec_n, 0);
        chk(s_ready == 1'b1, "R9 ready after flush", int'(s_ready), 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule